// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a 16-bit physical address through a four-entry segment table. The two most significant address bits pick a table entry. The remaining twelve bits are an offset into that segment. Each entry holds three things: a physical base, a segment length, and an access permission code. A lookup passes only when the permission allows the access kind and the offset lies inside the segment. The physical address is then the base plus the offset. Any other lookup gives a fault with a cause code and no address.

Software loads the table one entry at a time through a write port. Swapping all four entries on a context switch gives the new process its own address map. Requests use a valid/ready handshake. Every accepted request gets exactly one registered response on the next clock. Reset marks every entry as inaccessible, so all lookups fault until the table has been loaded.

Top module: `seg_xlate`

## Requirements
- R1: The segment index is `req_addr[13:12]` and the offset is `req_addr[11:0]`.
- R2: A lookup that does not fault returns `rsp_paddr` = entry base + offset, truncated to 16 bits (it wraps past 0xFFFF). The response appears with `rsp_valid` high in the cycle after the request is accepted.
- R3: An offset greater than or equal to the entry length is a bounds fault: `rsp_fault`=1, `rsp_cause`=2'b01, `rsp_paddr`=0. Valid offsets run from 0 to length-1, and a length of 0x1000 admits every offset.
- R4: Permission codes are 2'b00 none, 2'b01 read-only and 2'b10 read-write, and 2'b11 behaves as none. Any access to a none segment is a permission fault, and so is a write (`req_write`=1) to a read-only segment. A permission fault gives `rsp_fault`=1, `rsp_cause`=2'b10, `rsp_paddr`=0.
- R5: When an access breaks both the permission rule and the bounds rule, the reported cause is permission (2'b10).
- R6: Reset clears every entry to base 0, length 0 and permission none. While reset is high, `req_ready` and `rsp_valid` are low. After reset, every lookup faults with cause permission until entries are loaded.
- R7: With `cfg_we` high, entry `cfg_idx` takes `cfg_base`, `cfg_size` and `cfg_prot` at the clock edge. A request accepted in the very next cycle already sees the new contents.
- R8: `req_ready` is low whenever `cfg_we` is high. `rsp_valid` is high in exactly those cycles that follow a cycle with `req_valid` and `req_ready` both high.
- R9: A lookup that does not fault reports `rsp_fault`=0 and `rsp_cause`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | Physical base for the entry |
| cfg_size | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_prot | input | 2 | Permission code for the entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Unit can accept a lookup this cycle |
| req_addr | input | 14 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 16 | Translated physical address, 0 on a fault |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_cause | output | 2 | 00 none, 01 bounds, 10 permission |

## Verification
On every cycle, the assertions check the handshake timing. They also check that the fault flag agrees with the cause code, that faulting responses carry a zero address, and that the cause matches a shadow copy of the table built from the write port. Only the bench scenarios can show the arithmetic. That covers the example mapping of 0x0240 to 0x4240, the exact edge offsets length-1 and length, the wrap past the top of the physical space, and the way a reload changes the results of later lookups.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    parameter int SEG_W = 2;
    parameter int OFF_W = 12;
    parameter int PA_W  = 16;

    localparam int VA_W   = SEG_W + OFF_W;
    localparam int NSEG   = 1 << SEG_W;
    localparam int SIZE_W = OFF_W + 1;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_RO   = 2'b01,
        PROT_RW   = 2'b10,
        PROT_RSVD = 2'b11
    } prot_e;

    typedef enum logic [1:0] {
        CAUSE_OK     = 2'b00,
        CAUSE_BOUNDS = 2'b01,
        CAUSE_PERM   = 2'b10
    } cause_e;

    typedef struct packed {
        logic [PA_W-1:0]   base;
        logic [SIZE_W-1:0] size;
        prot_e             prot;
    } seg_entry_t;

    typedef struct packed {
        logic            fault;
        cause_e          cause;
        logic [PA_W-1:0] paddr;
    } xlate_rsp_t;

    function automatic logic access_allowed(prot_e p, logic wr);
        case (p)
            PROT_RW: access_allowed = 1'b1;
            PROT_RO: access_allowed = ~wr;
            default: access_allowed = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_entry_t       wr_entry,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);
    seg_entry_t entries_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries_q[i] <= '{base: '0, size: '0, prot: PROT_NONE};
            end else if (wr_en && wr_idx == SEG_W'(i)) begin
                entries_q[i] <= wr_entry;
            end
        end
    end

    assign rd_entry = entries_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  seg_entry_t       entry,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_write,
    output xlate_rsp_t       result
);
    logic            out_of_range;
    logic            perm_denied;
    logic [PA_W-1:0] sum;

    assign out_of_range = {1'b0, offset} >= entry.size;
    assign perm_denied  = ~access_allowed(entry.prot, is_write);
    assign sum          = entry.base + {{(PA_W-OFF_W){1'b0}}, offset};

    always_comb begin
        result = '{fault: 1'b0, cause: CAUSE_OK, paddr: sum};
        if (perm_denied) begin
            result = '{fault: 1'b1, cause: CAUSE_PERM, paddr: '0};
        end else if (out_of_range) begin
            result = '{fault: 1'b1, cause: CAUSE_BOUNDS, paddr: '0};
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [1:0]        cfg_prot,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    seg_entry_t wr_entry;
    seg_entry_t cur_entry;
    xlate_rsp_t lookup;
    xlate_rsp_t rsp_q;
    logic       rsp_valid_q;
    logic       accept;

    assign wr_entry = '{base: cfg_base, size: cfg_size, prot: prot_e'(cfg_prot)};

    seg_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .rd_idx   (req_addr[VA_W-1:OFF_W]),
        .rd_entry (cur_entry)
    );

    seg_check u_check (
        .entry    (cur_entry),
        .offset   (req_addr[OFF_W-1:0]),
        .is_write (req_write),
        .result   (lookup)
    );

    assign req_ready = ~rst & ~cfg_we;
    assign accept    = req_valid & req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '{fault: 1'b0, cause: CAUSE_OK, paddr: '0};
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_q <= lookup;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [SEG_W-1:0]  cfg_idx,
    input logic [SIZE_W-1:0] cfg_size,
    input logic [1:0]        cfg_prot,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_addr,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause
);
    logic [1:0]        sh_prot [NSEG];
    logic [SIZE_W-1:0] sh_size [NSEG];
    logic [1:0]        want_cause;
    logic [1:0]        want_cause_q;
    logic [SEG_W-1:0]  idx;

    assign idx = req_addr[VA_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSEG; i++) begin
                sh_prot[i] <= 2'b00;
                sh_size[i] <= '0;
            end
        end else if (cfg_we) begin
            sh_prot[cfg_idx] <= cfg_prot;
            sh_size[cfg_idx] <= cfg_size;
        end
    end

    always_comb begin
        if (sh_prot[idx] == 2'b00 || sh_prot[idx] == 2'b11 ||
            (sh_prot[idx] == 2'b01 && req_write)) begin
            want_cause = 2'b10;
        end else if ({1'b0, req_addr[OFF_W-1:0]} >= sh_size[idx]) begin
            want_cause = 2'b01;
        end else begin
            want_cause = 2'b00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            want_cause_q <= 2'b00;
        end else if (req_valid && req_ready) begin
            want_cause_q <= want_cause;
        end
    end

    p_rsp_timing_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));

    p_ready_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !req_ready);

    p_idle_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    p_fault_flag_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)));

    p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    p_cause_match_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_cause == want_cause_q));

    p_cause_legal_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_cause != 2'b11));
endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_size  (cfg_size),
    .cfg_prot  (cfg_prot),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_size = '0;
    logic [1:0]  cfg_prot = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 0;
    int  m_base [4];
    int  m_size [4];
    int  m_prot [4];

    always #10 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_prot(cfg_prot),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_size[i] = 0; m_prot[i] = 0;
        end
    endtask

    // One cycle: drive at a falling edge, check the response at the next one.
    task automatic step(bit we, int idx, int base, int size, int prot,
                        bit v, int addr, bit wr, string tag);
        int seg, off, e_pa, e_fault, e_cause;
        bit acc, perm_bad;
        cfg_we = we; cfg_idx = idx[1:0]; cfg_base = base[15:0];
        cfg_size = size[12:0]; cfg_prot = prot[1:0];
        req_valid = v; req_addr = addr[13:0]; req_write = wr;
        #1;
        check("R8", "req_ready", int'(req_ready), int'(!rst && !we));
        acc = v && !rst && !we;
        seg = (addr >> 12) & 3;   // R1
        off = addr & 'hFFF;
        perm_bad = (m_prot[seg] == 0) || (m_prot[seg] == 3) || (wr && m_prot[seg] == 1);
        if (perm_bad) begin
            e_fault = 1; e_cause = 2; e_pa = 0;
        end else if (off >= m_size[seg]) begin
            e_fault = 1; e_cause = 1; e_pa = 0;
        end else begin
            e_fault = 0; e_cause = 0; e_pa = (m_base[seg] + off) & 'hFFFF;
        end
        @(negedge clk);
        check(acc ? tag : "R8", "rsp_valid", int'(rsp_valid), int'(acc));
        if (acc) begin
            check(tag, "rsp_paddr", int'(rsp_paddr), e_pa);
            check(tag, "rsp_fault", int'(rsp_fault), e_fault);
            check(tag, "rsp_cause", int'(rsp_cause), e_cause);
        end
        if (rst) model_reset();
        else if (we) begin
            m_base[idx] = base; m_size[idx] = size; m_prot[idx] = prot;
        end
    endtask

    task automatic load(int idx, int base, int size, int prot);
        step(1, idx, base, size, prot, 0, 0, 0, "R7");
    endtask

    task automatic look(int addr, bit wr, string tag);
        step(0, 0, 0, 0, 0, 1, addr, wr, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R6: reset holds ready and response low even with a request pending
        step(0, 0, 0, 0, 0, 1, 'h0240, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 'h0240, 0, "R6");
        rst = 1'b0;
        // R6: untouched table faults every access with permission cause
        look('h0240, 0, "R6");
        look('h3010, 1, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");

        // R7: load the example map, segment 1 read-only
        load(0, 'h4000, 'h700, 2);
        load(1, 'h0000, 'h500, 1);
        load(2, 'h2000, 'h1000, 2);
        look('h0240, 0, "R2");        // 0x4240
        look('h0240, 1, "R9");        // write to RW ok
        look('h1108, 0, "R1");        // 0x0108
        look('h1108, 1, "R4");        // write to read-only
        look('h06FF, 0, "R3");        // last valid offset
        look('h0700, 0, "R3");        // equal to length
        look('h2FFF, 1, "R3");        // full-size segment
        look('h3000, 0, "R4");        // segment 3 still none
        look('h1600, 1, "R5");        // both violations -> permission

        // R8: write and request in the same cycle; request not taken
        step(1, 3, 'hF800, 'h1000, 2, 1, 'h3900, 0, "R8");
        look('h3900, 0, "R2");        // wraps to 0x0100
        look('h3FFF, 1, "R2");
        // R4: reserved code behaves as none
        load(3, 'h1000, 'h1000, 3);
        look('h3004, 0, "R4");
        // R3: zero length rejects offset 0
        load(2, 'h2000, 0, 2);
        look('h2000, 0, "R3");
        // R7: context switch rewrites segment 0, next-cycle lookup sees it
        load(0, 'h8000, 'h100, 1);
        look('h0050, 0, "R7");
        look('h0050, 1, "R4");
        look('h0100, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");

        // R6: reset again clears the table
        rst = 1'b1;
        step(0, 0, 0, 0, 0, 1, 'h0050, 0, "R6");
        rst = 1'b0;
        look('h0050, 0, "R6");

        finished = 1;
        summary();
        $finish;
    end
endmodule